// File: doc/BRIEF.md
# Scan Segment Insertion Bit

This block is a single-bit scan cell that sits in a serial test-data path and decides whether a downstream scan segment is spliced into that path. Scan data enters on `scan_in` and passes through the cell's own shift bit. That bit feeds the segment through `seg_scan_in`, and the segment's data comes back on `seg_return`. An output multiplexer sends either the cell's own bit or the segment's return data to `scan_out`.

The cell has two stages. The shift stage is clocked on the rising test clock and either shifts or captures. The update stage loads on the rising edge of the inverted test clock, which is the falling edge of the test clock. The update stage holds the open or closed state. That state steers the output multiplexer and, ANDed with the cell's own enable, drives `seg_select`. The segment uses `seg_select` to gate its own shift, capture and update controls, so a closed cell hides everything nested behind it.

The shift, capture and update controls each take effect only while `sel_on` is high. Cells can be nested by wiring one cell's `seg_select` to the `sel_on` input of an inner cell.

Top module: `scan_insert_bit`

## Requirements
- R1: Driving `rst_n` low clears the shift bit and the latched state at once, without waiting for a clock. After reset `seg_select`=0, `seg_scan_in`=0 and the path is closed.
- R2: When the latched state is 0 (closed), `scan_out` equals the cell's shift bit and `seg_return` has no effect. A marker bit takes 1 shift cycle to cross the cell.
- R3: When the latched state is 1 (open), `scan_out` equals `seg_return`. A marker takes 1 + L shift cycles to cross, where L is the segment length.
- R4: While `sel_on`=1 and `shift_dr`=1, the shift bit takes `scan_in` at each rising edge of `tck`. `seg_scan_in` always presents the shift bit.
- R5: While `sel_on`=1 and `update_dr`=1, the latched state loads the shift bit at the rising edge of `tck_n`, which is the falling edge of `tck`. It does not change at the rising edge of `tck` and otherwise holds.
- R6: Only the latched state steers the multiplexer. Shifting without an update leaves the path length unchanged.
- R7: While `sel_on`=1 and `capture_dr`=1, the shift bit loads the latched state at the rising edge of `tck`, so a read-back returns the open or closed state. If `shift_dr` is also high, the shift takes priority.
- R8: While `sel_on`=0, the shift, capture and update controls have no effect and both stages hold. `scan_out` still follows the current multiplexer selection.
- R9: `seg_select` equals the latched state ANDed with `sel_on`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; the shift stage acts on its rising edge |
| tck_n | input | 1 | Inverted test clock; the update stage acts on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_on | input | 1 | Cell enable; gates the shift, capture and update controls |
| shift_dr | input | 1 | Shift control for the data register |
| capture_dr | input | 1 | Capture control for the data register |
| update_dr | input | 1 | Update control for the data register |
| scan_in | input | 1 | Serial scan data in |
| seg_return | input | 1 | Scan data returning from the downstream segment |
| scan_out | output | 1 | Serial scan data out |
| seg_scan_in | output | 1 | Scan data sent into the downstream segment (the shift bit) |
| seg_select | output | 1 | Enable for the downstream segment's controls |

## Verification
The path length is measured by flushing zeros through the path, injecting a single 1 and counting shift cycles until that 1 appears at `scan_out`. The test is run with the cell closed, after it has been opened, after it has been shifted without an update, and after it has been closed again. A result of 1 against 1 + L separates the two multiplexer selections. An unchanged length after shifting without an update shows that the multiplexer follows the latched state and not the shift stage.

The reset state is checked while `seg_return` is held at 1, so a multiplexer stuck on the return path cannot pass. Capture is tried in both states and together with shift, which separates capture from hold and shows which control wins. Every control is also applied with `sel_on` low; the outputs staying put shows the gating, and a return to `sel_on`=1 shows that the latched state was kept.

// File: rtl/sib_pkg.sv
package sib_pkg;
  typedef enum logic {
    SEG_BYPASS  = 1'b0,
    SEG_SPLICED = 1'b1
  } seg_state_e;

  typedef struct packed {
    logic shift_en;
    logic capture_en;
    logic update_en;
    logic clk_en;
  } sib_ctl_t;
endpackage

// File: rtl/sib_ctrl_gate.sv
module sib_ctrl_gate
  import sib_pkg::*;
(
  input  logic     sel_on,
  input  logic     shift_dr,
  input  logic     capture_dr,
  input  logic     update_dr,
  output sib_ctl_t ctl
);
  // Each raw control counts only while the cell is enabled.
  always_comb begin
    ctl.shift_en   = sel_on & shift_dr;
    ctl.capture_en = sel_on & capture_dr;
    ctl.update_en  = sel_on & update_dr;
    // The shift stage is clocked in both capture and shift cycles.
    ctl.clk_en     = sel_on & (shift_dr | capture_dr);
  end
endmodule

// File: rtl/sib_shift_stage.sv
module sib_shift_stage
  import sib_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  sib_ctl_t   ctl,
  input  logic       scan_in,
  input  seg_state_e state_q,
  output logic       shift_q
);
  logic shift_d;

  // Shift wins over capture; capture reloads the latched state.
  always_comb begin
    shift_d = shift_q;
    if (ctl.shift_en)        shift_d = scan_in;
    else if (ctl.capture_en) shift_d = (state_q == SEG_SPLICED);
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)          shift_q <= 1'b0;
    else if (ctl.clk_en) shift_q <= shift_d;
  end
endmodule

// File: rtl/sib_update_stage.sv
module sib_update_stage
  import sib_pkg::*;
(
  input  logic       tck_n,
  input  logic       rst_n,
  input  sib_ctl_t   ctl,
  input  logic       shift_q,
  output seg_state_e state_q
);
  seg_state_e state_d;

  always_comb begin
    state_d = shift_q ? SEG_SPLICED : SEG_BYPASS;
  end

  // Loads on the falling test-clock edge, half a cycle after the last shift.
  always_ff @(posedge tck_n or negedge rst_n) begin
    if (!rst_n)             state_q <= SEG_BYPASS;
    else if (ctl.update_en) state_q <= state_d;
  end
endmodule

// File: rtl/sib_out_mux.sv
module sib_out_mux
  import sib_pkg::*;
(
  input  seg_state_e state_q,
  input  logic       sel_on,
  input  logic       shift_q,
  input  logic       seg_return,
  output logic       scan_out,
  output logic       seg_scan_in,
  output logic       seg_select
);
  always_comb begin
    seg_scan_in = shift_q;
    scan_out    = (state_q == SEG_SPLICED) ? seg_return : shift_q;
    seg_select  = (state_q == SEG_SPLICED) & sel_on;
  end
endmodule

// File: rtl/scan_insert_bit.sv
module scan_insert_bit
  import sib_pkg::*;
(
  input  logic tck,
  input  logic tck_n,
  input  logic rst_n,
  input  logic sel_on,
  input  logic shift_dr,
  input  logic capture_dr,
  input  logic update_dr,
  input  logic scan_in,
  input  logic seg_return,
  output logic scan_out,
  output logic seg_scan_in,
  output logic seg_select
);
  sib_ctl_t   ctl;
  logic       shift_q;
  seg_state_e state_q;

  sib_ctrl_gate u_gate (
    .sel_on     (sel_on),
    .shift_dr   (shift_dr),
    .capture_dr (capture_dr),
    .update_dr  (update_dr),
    .ctl        (ctl)
  );

  sib_shift_stage u_shift (
    .tck     (tck),
    .rst_n   (rst_n),
    .ctl     (ctl),
    .scan_in (scan_in),
    .state_q (state_q),
    .shift_q (shift_q)
  );

  sib_update_stage u_upd (
    .tck_n   (tck_n),
    .rst_n   (rst_n),
    .ctl     (ctl),
    .shift_q (shift_q),
    .state_q (state_q)
  );

  sib_out_mux u_mux (
    .state_q     (state_q),
    .sel_on      (sel_on),
    .shift_q     (shift_q),
    .seg_return  (seg_return),
    .scan_out    (scan_out),
    .seg_scan_in (seg_scan_in),
    .seg_select  (seg_select)
  );
endmodule

// File: rtl/scan_insert_bit_chk.sv
module scan_insert_bit_chk (
  input logic tck,
  input logic rst_n,
  input logic sel_on,
  input logic shift_dr,
  input logic capture_dr,
  input logic scan_in,
  input logic seg_return,
  input logic scan_out,
  input logic seg_scan_in,
  input logic seg_select
);
  AST_RESET_CLEARS: assert property (@(posedge tck)
    !rst_n |-> (!seg_select && !seg_scan_in)); // R1

  AST_CLOSED_OWN_BIT: assert property (@(posedge tck) disable iff (!rst_n)
    (sel_on && !seg_select) |-> (scan_out == seg_scan_in)); // R2

  AST_OPEN_RETURN: assert property (@(posedge tck) disable iff (!rst_n)
    seg_select |-> (scan_out == seg_return)); // R3

  AST_SHIFT_TAKES_IN: assert property (@(posedge tck) disable iff (!rst_n)
    (sel_on && shift_dr) |=> (seg_scan_in == $past(scan_in))); // R4

  AST_OFF_HOLDS: assert property (@(posedge tck) disable iff (!rst_n)
    (!sel_on) |=> $stable(seg_scan_in)); // R8

  AST_IDLE_HOLDS: assert property (@(posedge tck) disable iff (!rst_n)
    (!shift_dr && !capture_dr) |=> $stable(seg_scan_in)); // R7

  AST_SELECT_NEEDS_ON: assert property (@(posedge tck) disable iff (!rst_n)
    seg_select |-> sel_on); // R9
endmodule

bind scan_insert_bit scan_insert_bit_chk u_chk (
  .tck         (tck),
  .rst_n       (rst_n),
  .sel_on      (sel_on),
  .shift_dr    (shift_dr),
  .capture_dr  (capture_dr),
  .scan_in     (scan_in),
  .seg_return  (seg_return),
  .scan_out    (scan_out),
  .seg_scan_in (seg_scan_in),
  .seg_select  (seg_select)
);

// File: tb/scan_insert_bit_tb.sv
module scan_insert_bit_tb;
  localparam int SEG_LEN = 4;

  logic tck = 1'b0;
  logic tck_n;
  logic rst_n, sel_on, shift_dr, capture_dr, update_dr, scan_in;
  logic seg_return, scan_out, seg_scan_in, seg_select;
  logic [SEG_LEN-1:0] seg;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 tck = ~tck;
  assign tck_n = ~tck;

  // Downstream segment model: shifts only while the cell selects it.
  always @(posedge tck or negedge rst_n) begin
    if (!rst_n) seg <= '1;
    else if (seg_select && shift_dr) seg <= {seg[SEG_LEN-2:0], seg_scan_in};
  end
  assign seg_return = seg[SEG_LEN-1];

  scan_insert_bit u_dut (
    .tck(tck), .tck_n(tck_n), .rst_n(rst_n), .sel_on(sel_on),
    .shift_dr(shift_dr), .capture_dr(capture_dr), .update_dr(update_dr),
    .scan_in(scan_in), .seg_return(seg_return), .scan_out(scan_out),
    .seg_scan_in(seg_scan_in), .seg_select(seg_select)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge tck);
    #2;
  endtask

  task automatic measure_len(output int len);
    shift_dr = 1'b1;
    scan_in  = 1'b0;
    repeat (SEG_LEN + 3) step();
    scan_in = 1'b1;
    step();
    scan_in = 1'b0;
    len = 0;
    for (int k = 1; k <= SEG_LEN + 4; k++) begin
      if (scan_out === 1'b1 && len == 0) len = k;
      step();
    end
    shift_dr = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; sel_on = 1'b1; shift_dr = 1'b0; capture_dr = 1'b0;
    update_dr = 1'b0; scan_in = 1'b0;
    repeat (2) step();
    check("R1 seg_select after reset", seg_select, 0);
    check("R1 seg_scan_in after reset", seg_scan_in, 0);
    check("R2 scan_out ignores seg_return=1 when closed", scan_out, 0);
    rst_n = 1'b1;
    step();
  endtask

  task automatic t_closed_len();
    int len;
    measure_len(len);
    check("R2 closed path length", len, 1);
  endtask

  task automatic t_open();
    int len;
    shift_dr = 1'b1; scan_in = 1'b1;
    step();
    shift_dr = 1'b0; scan_in = 1'b0;
    update_dr = 1'b1;
    #1;
    check("R5 no update before falling edge", seg_select, 0);
    step();
    update_dr = 1'b0;
    check("R5 opened after falling edge", seg_select, 1);
    check("R9 seg_select with sel_on high", seg_select, 1);
    measure_len(len);
    check("R3 open path length", len, SEG_LEN + 1);
    measure_len(len);
    check("R6 length kept after shift without update", len, SEG_LEN + 1);
  endtask

  task automatic t_capture_open();
    // Shift bit is 0 after the flush; capture must reload the open state.
    check("R4 seg_scan_in after zero flush", seg_scan_in, 0);
    capture_dr = 1'b1;
    step();
    capture_dr = 1'b0;
    check("R7 capture returns open state", seg_scan_in, 1);
  endtask

  task automatic t_off();
    logic sb;
    sb = seg_scan_in;
    sel_on = 1'b0; shift_dr = 1'b1; scan_in = ~sb; update_dr = 1'b1;
    capture_dr = 1'b1;
    #1;
    check("R9 seg_select drops with sel_on low", seg_select, 0);
    step();
    check("R8 shift bit held while off", seg_scan_in, sb);
    check("R8 scan_out follows mux while off", scan_out, seg_return);
    shift_dr = 1'b0; update_dr = 1'b0; capture_dr = 1'b0; scan_in = 1'b0;
    sel_on = 1'b1;
    #1;
    check("R8 latched state held while off", seg_select, 1);
    step();
  endtask

  task automatic t_close();
    int len;
    shift_dr = 1'b1; scan_in = 1'b0;
    step();
    shift_dr = 1'b0; update_dr = 1'b1;
    step();
    update_dr = 1'b0;
    check("R5 closed after update of 0", seg_select, 0);
    measure_len(len);
    check("R2 path length back to 1", len, 1);
  endtask

  task automatic t_capture_closed();
    shift_dr = 1'b1; capture_dr = 1'b1; scan_in = 1'b1;
    step();
    check("R7 shift wins over capture", seg_scan_in, 1);
    shift_dr = 1'b0; scan_in = 1'b0;
    step();
    capture_dr = 1'b0;
    check("R7 capture returns closed state", seg_scan_in, 0);
  endtask

  task automatic t_async_reset();
    shift_dr = 1'b1; scan_in = 1'b1;
    step();
    shift_dr = 1'b0; update_dr = 1'b1;
    step();
    update_dr = 1'b0;
    check("R5 reopened", seg_select, 1);
    rst_n = 1'b0;
    #1;
    check("R1 async reset closes at once", seg_select, 0);
    check("R1 async reset clears shift bit", seg_scan_in, 0);
    step();
    rst_n = 1'b1;
    step();
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_closed_len();
    t_open();
    t_capture_open();
    t_off();
    t_close();
    t_capture_closed();
    t_async_reset();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule